// File: doc/BRIEF.md
# Staged Power-On Reset Sequencer

This block releases the resets of a controller chip one stage at a time once the external supply monitor reports that power is good. A power-sense level from that monitor is synchronised into the reference clock domain. While it is low, every reset is held and all pin drivers are off. When sense goes high, the clock generator's reset is released first. The core and processor then stay in reset for a fixed settling interval, counted in reference clock cycles, so the PLL can lock.

After the settling interval the core reset is released and the pin drivers are enabled, and the processor starts booting. When the processor signals that its boot step is complete, the block drops a busy flag. A host polls this flag to decide when to raise its project-on request. The final stage is enabled only after that request. A request that comes in early, before the processor reports completion, is remembered and acted on as soon as completion arrives. If sense drops at any time, the block returns straight to full reset.

The settling interval is `REF_CLK_HZ / 1000 * LOCK_MS` cycles. The default is 60 ms at 100 MHz.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst_n` is low and just after it rises with sense low, the outputs are pll_rst=1, core_rst=1, io_oe=0, final_en=0, busy=1.
- R2: The sense input passes through a two-flop synchroniser. After sense rises, `pll_rst_o` goes low following the third rising clock edge, and the other outputs keep their full-reset values.
- R3: `core_rst_o` stays high for exactly LOCK_CYCLES clock cycles after `pll_rst_o` falls, then falls. LOCK_CYCLES is REF_CLK_HZ/1000*LOCK_MS.
- R4: `io_oe_o` is high exactly when `core_rst_o` is low. It is never high during the settling interval.
- R5: `busy_o` is high in full reset, during settling and while the processor boots. It falls on the edge that samples `boot_done_i` high during boot.
- R6: `final_en_o` rises only on the edge that samples `proj_on_i` high, or a remembered request. While the block waits for the host, `final_en_o` stays low with `busy_o` low.
- R7: A `proj_on_i` pulse seen during settling or boot is held. When `boot_done_i` arrives, the block goes straight to the final stage (final_en=1, busy=0) on that edge.
- R8: If sense goes low in any stage, the outputs return to full reset following the third clock edge. The settling counter clears, so the next power-up waits the full LOCK_CYCLES again.
- R9: `boot_done_i` has no effect outside the boot stage. A pulse during settling does not shorten the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| pwr_sense_i | input | 1 | Power-good level from the external monitor (asynchronous) |
| proj_on_i | input | 1 | Host request to run the final boot stage |
| boot_done_i | input | 1 | Processor reports that its boot step is complete |
| pll_rst_o | output | 1 | PLL reset, active high |
| core_rst_o | output | 1 | Core and processor reset, active high |
| io_oe_o | output | 1 | Output enable for the pin drivers; low means tri-stated |
| final_en_o | output | 1 | Enable for the final boot stage |
| busy_o | output | 1 | Status flag a host may poll; low means ready for project-on |

## Verification
The bench counts the settling interval to the exact cycle from the PLL release. A counter off by one would release the core a cycle early or late. It pulses boot-done during settling; a design that honoured it there would skip part of the lock time. It drops sense halfway through settling and then powers up again, so a counter that is not cleared would release the core too soon on the second power-up. A project-on pulse is sent before boot-done, so a design that lost the early request would sit with busy low and the final stage off.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_FULL_RESET = 3'd0,
        ST_PLL_SETTLE = 3'd1,
        ST_CPU_BOOT   = 3'd2,
        ST_HOST_WAIT  = 3'd3,
        ST_RUN        = 3'd4
    } seq_state_e;

    // Settling interval in reference clock cycles.
    function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                  input int unsigned ms);
        return (clk_hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    assign level_o = s_q.chain[STAGES-1];
    assign rise_o  = level_o & ~s_q.prev;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.prev  = level_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: an edge yields a single-cycle pulse
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int unsigned COUNT = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [W-1:0] LAST = W'(COUNT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done_o = run_i && (t_q.cnt == LAST);

    always_comb begin
        t_d = t_q;
        if (!run_i || done_o) t_d.cnt = '0;
        else                  t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R3: count never passes the final value
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LAST);

    // R8: leaving the settle stage clears the count
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> t_q.cnt == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sense_lvl_i,
    input  logic sense_rise_i,
    input  logic settle_done_i,
    input  logic boot_done_i,
    input  logic proj_on_i,
    output logic settle_run_o,
    output logic pll_rst_o,
    output logic core_rst_o,
    output logic io_oe_o,
    output logic final_en_o,
    output logic busy_o
);

    typedef struct packed {
        seq_state_e state;
        logic       pend;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            ST_FULL_RESET: begin
                f_d.pend = 1'b0;
                if (sense_rise_i) f_d.state = ST_PLL_SETTLE;
            end
            ST_PLL_SETTLE: begin
                if (proj_on_i)     f_d.pend  = 1'b1;
                if (settle_done_i) f_d.state = ST_CPU_BOOT;
            end
            ST_CPU_BOOT: begin
                if (proj_on_i) f_d.pend = 1'b1;
                if (boot_done_i) begin
                    f_d.state = (f_q.pend || proj_on_i) ? ST_RUN : ST_HOST_WAIT;
                    f_d.pend  = 1'b0;
                end
            end
            ST_HOST_WAIT: begin
                if (proj_on_i) f_d.state = ST_RUN;
            end
            ST_RUN: begin
                f_d.state = ST_RUN;
            end
            default: begin
                f_d.state = ST_FULL_RESET;
                f_d.pend  = 1'b0;
            end
        endcase
        if (!sense_lvl_i) begin
            f_d.state = ST_FULL_RESET;
            f_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_FULL_RESET, pend: 1'b0};
        else        f_q <= f_d;
    end

    always_comb begin
        settle_run_o = (f_q.state == ST_PLL_SETTLE);
        pll_rst_o    = (f_q.state == ST_FULL_RESET);
        core_rst_o   = (f_q.state == ST_FULL_RESET) || (f_q.state == ST_PLL_SETTLE);
        io_oe_o      = !core_rst_o;
        final_en_o   = (f_q.state == ST_RUN);
        busy_o       = (f_q.state != ST_HOST_WAIT) && (f_q.state != ST_RUN);
    end

    // R2: PLL leaves reset only after a synchronised rising edge
    p_pll_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_o) |-> $past(sense_rise_i));

    // R3: core leaves reset only when the settle timer has expired
    p_core_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> $past(settle_done_i));

    // R5: busy drops only on processor completion
    p_busy_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(boot_done_i));

    // R6: final stage needs a live or remembered host request
    p_final_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(final_en_o) |-> ($past(proj_on_i) || $past(f_q.pend)));

    // R8: loss of sense forces full reset on the next edge
    p_sense_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_lvl_i |=> (pll_rst_o && core_rst_o && !io_oe_o && !final_en_o));

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
    parameter int unsigned REF_CLK_HZ  = 100_000_000,
    parameter int unsigned LOCK_MS     = 60,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_sense_i,
    input  logic proj_on_i,
    input  logic boot_done_i,
    output logic pll_rst_o,
    output logic core_rst_o,
    output logic io_oe_o,
    output logic final_en_o,
    output logic busy_o
);

    localparam int unsigned LOCK_CYCLES =
        pwrseq_pkg::settle_cycles(REF_CLK_HZ, LOCK_MS);

    logic sense_lvl;
    logic sense_rise;
    logic settle_run;
    logic settle_done;

    pwrseq_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwr_sense_i),
        .level_o (sense_lvl),
        .rise_o  (sense_rise)
    );

    pwrseq_timer #(
        .COUNT (LOCK_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (settle_run),
        .done_o (settle_done)
    );

    pwrseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sense_lvl_i   (sense_lvl),
        .sense_rise_i  (sense_rise),
        .settle_done_i (settle_done),
        .boot_done_i   (boot_done_i),
        .proj_on_i     (proj_on_i),
        .settle_run_o  (settle_run),
        .pll_rst_o     (pll_rst_o),
        .core_rst_o    (core_rst_o),
        .io_oe_o       (io_oe_o),
        .final_en_o    (final_en_o),
        .busy_o        (busy_o)
    );

endmodule

// File: tb/tb_pwrseq_top.sv
`timescale 1ns/1ps
module tb_pwrseq_top;

    localparam int unsigned HZ = 1000;
    localparam int unsigned MS = 60;
    localparam int L = (HZ / 1000) * MS;

    // {pll_rst, core_rst, io_oe, final_en, busy}
    localparam logic [4:0] E_RST  = 5'b11001;
    localparam logic [4:0] E_LOCK = 5'b01001;
    localparam logic [4:0] E_BOOT = 5'b00101;
    localparam logic [4:0] E_WAIT = 5'b00100;
    localparam logic [4:0] E_RUN  = 5'b00110;

    logic clk = 1'b0;
    logic rst_n, sense, proj_on, boot_done;
    logic pll_rst, core_rst, io_oe, final_en, busy;

    always #2.5 clk = ~clk;

    pwrseq_top #(.REF_CLK_HZ(HZ), .LOCK_MS(MS)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_sense_i(sense), .proj_on_i(proj_on),
        .boot_done_i(boot_done), .pll_rst_o(pll_rst), .core_rst_o(core_rst),
        .io_oe_o(io_oe), .final_en_o(final_en), .busy_o(busy));

    typedef struct {
        logic [4:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Driver: expectation for the outputs after the coming rising edge.
    task automatic expect_next(input logic [4:0] e, input string r);
        item_t it;
        it.exp = e;
        it.req = r;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_n(input logic [4:0] e, input string r, input int n);
        for (int i = 0; i < n; i++) expect_next(e, r);
    endtask

    // Monitor: pops and compares after each rising edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if ({pll_rst, core_rst, io_oe, final_en, busy} !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", it.req,
                             {pll_rst, core_rst, io_oe, final_en, busy}, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sense = 1'b0; proj_on = 1'b0; boot_done = 1'b0;
        @(negedge clk);
        expect_n(E_RST, "R1", 3);
        rst_n = 1'b1;
        expect_n(E_RST, "R1", 2);

        // Power-up, settle, boot, host request
        sense = 1'b1;
        expect_n(E_RST, "R2", 2);
        expect_next(E_LOCK, "R2");
        for (int i = 1; i < L; i++) begin
            boot_done = (i == 10);
            expect_next(E_LOCK, (i == 10) ? "R9" : "R3");
        end
        boot_done = 1'b0;
        expect_next(E_BOOT, "R3 R4");
        expect_n(E_BOOT, "R5", 3);
        boot_done = 1'b1;
        expect_next(E_WAIT, "R5");
        boot_done = 1'b0;
        expect_n(E_WAIT, "R6", 3);
        proj_on = 1'b1;
        expect_next(E_RUN, "R6");
        proj_on = 1'b0;
        expect_n(E_RUN, "R6", 2);

        // Sense loss from the final stage
        sense = 1'b0;
        expect_n(E_RUN, "R8", 2);
        expect_next(E_RST, "R8");
        expect_n(E_RST, "R8", 2);

        // Sense loss mid-settle, then full restart with early request
        sense = 1'b1;
        expect_n(E_RST, "R2", 2);
        expect_next(E_LOCK, "R2");
        expect_n(E_LOCK, "R8", 19);
        sense = 1'b0;
        expect_n(E_LOCK, "R8", 2);
        expect_next(E_RST, "R8");
        expect_n(E_RST, "R8", 2);
        sense = 1'b1;
        expect_n(E_RST, "R2", 2);
        expect_next(E_LOCK, "R8");
        for (int i = 1; i < L; i++) begin
            proj_on = (i == 5);
            expect_next(E_LOCK, "R8");
        end
        proj_on = 1'b0;
        expect_next(E_BOOT, "R8");
        expect_n(E_BOOT, "R7", 2);
        boot_done = 1'b1;
        expect_next(E_RUN, "R7");
        boot_done = 1'b0;
        expect_n(E_RUN, "R7", 2);

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule